// File: doc/BRIEF.md
# Watchdog and Interval Timer

An 8-bit up-counter that advances on a prescaler strobe and can serve either as a periodic interval timer or as a system watchdog. A small register bus reaches three locations: the counter itself, a control/status register (overflow flag, mode select, run enable), and a reset-control register (reset enable, action select). When the counter wraps from its all-ones value to zero, the block sets an overflow flag. The mode bit then decides what happens next. In interval mode the flag raises a level interrupt request. In watchdog mode the wrap produces a one-cycle internal reset request, or, when the action-select option is built in and chosen, a one-cycle non-maskable interrupt request.

The overflow flag is guarded against careless clearing. Software must first read the control/status register while the flag is already set. Only a later write of 0 to the flag bit then clears it. A read that lands in the same cycle as the wrap that sets the flag does not count. The flag also drops when the block's own reset request fires, and, in the action-select build, when software writes the run-enable bit to 0.

Top module: `wdog_itimer`

## Requirements
- R1: The counter (address 0) advances by one at a clock edge only when the run bit (control bit 5) is 1 and `tick_i` is high in that cycle. A bus write to address 0 loads the written value and takes priority over a tick in the same cycle.
- R2: When the counter advances from 0xFF, it becomes 0x00 and the overflow flag (control/status bit 7, address 1) reads 1 from the next cycle.
- R3: A write of 0 to bit 7 of address 1 clears the flag only if address 1 was read while the flag was 1 at some point since the flag last became set. A write of 0 with no such read, or a write of 1 to bit 7, leaves the flag at 1.
- R4: A read of address 1 made in the same cycle as the wrap that sets the flag returns bit 7 = 0 and does not enable a later clearing write.
- R5: With the mode bit (control bit 6) at 0, `irq_interval_o` is high exactly while the flag is set. With the mode bit at 1, `irq_interval_o` stays low.
- R6: With the mode bit at 1, reset-enable (address 2, bit 6) at 1 and action select (address 2, bit 5) at 0, a wrap drives `rst_req_o` high for exactly the one cycle after the wrap edge. The flag reads 1 during that cycle and 0 afterwards. With reset-enable at 0, no reset request is produced and the flag stays set.
- R7: With the mode bit at 1 and action select at 1, a wrap drives `nmi_req_o` high for one cycle instead of `rst_req_o`, and the flag remains set.
- R8: A write to address 1 with bit 5 = 0 clears the flag whether or not a qualifying read happened.
- R9: After reset the counter, all register bits, and all three request outputs are 0.
- R10: Address 2 reads back only bits 6 and 5, with all other bits 0. Address 3 reads 0. Bits 4..0 of address 1 read 0.

Ports: see below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Prescaler strobe; one counter step per high cycle while running |
| bus_sel_i | input | 1 | Bus access in this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | 0 counter, 1 control/status, 2 reset control |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid in the same cycle as the read |
| irq_interval_o | output | 1 | Level interval interrupt request |
| rst_req_o | output | 1 | One-cycle internal reset request |
| nmi_req_o | output | 1 | One-cycle non-maskable interrupt request |

## Verification
Read data is combinational and is compared in the cycle of the read. A tick or write updates the counter and flag at the closing edge, so it shows on the next cycle's read. The interval request follows the flag and is due in the first cycle after the wrap edge. The reset and NMI pulses are registered and are due exactly one cycle after the wrap cycle. The auto-clear is visible one cycle after that. Each stimulus task stamps its expected items with the cycle in which the result is due. The monitor compares every item in the middle of exactly that cycle and flags any item still pending at the end.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  // Register map selector
  typedef enum logic [ADDR_W-1:0] {
    SEL_COUNT  = 2'd0,
    SEL_CTRL   = 2'd1,
    SEL_RSTCTL = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  // Control/status bit positions
  localparam int CTRL_FLAG_B = 7;
  localparam int CTRL_MODE_B = 6;
  localparam int CTRL_RUN_B  = 5;

  // Reset-control bit positions
  localparam int RC_ENA_B = 6;
  localparam int RC_NMI_B = 5;

  typedef enum logic {
    MODE_INTERVAL = 1'b0,
    MODE_WATCHDOG = 1'b1
  } tmr_mode_e;

  typedef struct packed {
    logic mode;
    logic run;
  } ctrl_t;

  typedef struct packed {
    logic rst_ena;
    logic nmi_sel;
  } rstctl_t;

endpackage

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             adv;
  logic             cnt_ce;

  // A load always wins over a tick in the same cycle
  always_comb begin
    adv    = run_i & tick_i & ~load_i;
    cnt_ce = load_i | adv;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (adv) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = adv & (cnt_q == CNT_MAX);

endmodule

// File: rtl/wdog_ovf_flag.sv
module wdog_ovf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,      // counter wrap this cycle
  input  logic rd_i,       // status register read this cycle
  input  logic clr_wr_i,   // status write carrying 0 in the flag bit
  input  logic force_clr_i,// run bit written to 0 (option build)
  input  logic auto_clr_i, // own reset request active
  output logic flag_o
);

  logic flag_q, flag_d;
  logic armed_q, armed_d;
  logic flag_ce, armed_ce;
  logic do_clear;

  // A read arms the clear only if the flag was already set when
  // the read cycle began; a read coinciding with the set does not.
  always_comb begin
    do_clear = (clr_wr_i & armed_q) | force_clr_i | auto_clr_i;
    flag_d   = flag_q;
    armed_d  = armed_q | (rd_i & flag_q);
    if (do_clear) begin
      flag_d  = 1'b0;
      armed_d = 1'b0;
    end
    if (set_i) begin
      flag_d = 1'b1;
    end
    flag_ce  = (flag_d != flag_q);
    armed_ce = (armed_d != armed_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_ce) begin
      flag_q <= flag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (armed_ce) begin
      armed_q <= armed_d;
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/wdog_req_gen.sv
module wdog_req_gen #(
  parameter bit ALT_ACTION = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap_i,
  input  logic mode_i,
  input  logic rst_ena_i,
  input  logic nmi_sel_i,
  input  logic flag_i,
  output logic irq_o,
  output logic rst_req_o,
  output logic nmi_req_o
);

  import wdog_pkg::*;

  logic nmi_eff;
  logic wd_wrap;
  logic rst_q, rst_d;
  logic nmi_q, nmi_d;

  generate
    if (ALT_ACTION) begin : g_alt
      assign nmi_eff = nmi_sel_i;
    end else begin : g_plain
      logic unused_sel;
      assign unused_sel = nmi_sel_i;
      assign nmi_eff    = 1'b0;
    end
  endgenerate

  always_comb begin
    wd_wrap = wrap_i & (mode_i == MODE_WATCHDOG);
    rst_d   = wd_wrap & rst_ena_i & ~nmi_eff;
    nmi_d   = wd_wrap & nmi_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= 1'b0;
      nmi_q <= 1'b0;
    end else begin
      rst_q <= rst_d;
      nmi_q <= nmi_d;
    end
  end

  assign irq_o     = flag_i & (mode_i == MODE_INTERVAL);
  assign rst_req_o = rst_q;
  assign nmi_req_o = nmi_q;

endmodule

// File: rtl/wdog_itimer.sv
module wdog_itimer #(
  parameter int CNT_W      = 8,
  parameter bit ALT_ACTION = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       bus_sel_i,
  input  logic       bus_we_i,
  input  logic [1:0] bus_addr_i,
  input  logic [7:0] bus_wdata_i,
  output logic [7:0] bus_rdata_o,
  output logic       irq_interval_o,
  output logic       rst_req_o,
  output logic       nmi_req_o
);

  import wdog_pkg::*;

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  // Bus decode
  reg_sel_e sel;
  logic     wr_cnt, wr_ctrl, wr_rc, rd_ctrl;

  always_comb begin
    sel     = reg_sel_e'(bus_addr_i);
    wr_cnt  = bus_sel_i & bus_we_i & (sel == SEL_COUNT);
    wr_ctrl = bus_sel_i & bus_we_i & (sel == SEL_CTRL);
    wr_rc   = bus_sel_i & bus_we_i & (sel == SEL_RSTCTL);
    rd_ctrl = bus_sel_i & ~bus_we_i & (sel == SEL_CTRL);
  end

  // Control and reset-control registers
  ctrl_t   ctrl_q, ctrl_d;
  rstctl_t rc_q, rc_d;
  logic    mode_q, run_q, rste_q, nmisel_q;

  always_comb begin
    ctrl_d      = ctrl_q;
    ctrl_d.mode = bus_wdata_i[CTRL_MODE_B];
    ctrl_d.run  = bus_wdata_i[CTRL_RUN_B];
    rc_d         = rc_q;
    rc_d.rst_ena = bus_wdata_i[RC_ENA_B];
    rc_d.nmi_sel = ALT_ACTION ? bus_wdata_i[RC_NMI_B] : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rc_q <= '0;
    end else if (wr_rc) begin
      rc_q <= rc_d;
    end
  end

  assign mode_q   = ctrl_q.mode;
  assign run_q    = ctrl_q.run;
  assign rste_q   = rc_q.rst_ena;
  assign nmisel_q = rc_q.nmi_sel;

  // Counter
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_wrap;
  logic             cnt_load;

  assign cnt_load = wr_cnt;

  wdog_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load_i     (cnt_load),
    .load_val_i (bus_wdata_i[CNT_W-1:0]),
    .run_i      (run_q),
    .tick_i     (tick_i),
    .cnt_o      (cnt_q),
    .wrap_o     (cnt_wrap)
  );

  // Overflow flag with guarded clear
  logic ovf_flag;
  logic clr_wr, force_clr;
  logic rst_pulse;

  assign clr_wr    = wr_ctrl & ~bus_wdata_i[CTRL_FLAG_B];
  assign force_clr = ALT_ACTION & wr_ctrl & ~bus_wdata_i[CTRL_RUN_B];

  wdog_ovf_flag u_flag (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .set_i       (cnt_wrap),
    .rd_i        (rd_ctrl),
    .clr_wr_i    (clr_wr),
    .force_clr_i (force_clr),
    .auto_clr_i  (rst_pulse),
    .flag_o      (ovf_flag)
  );

  // Request outputs
  wdog_req_gen #(
    .ALT_ACTION (ALT_ACTION)
  ) u_req (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wrap_i    (cnt_wrap),
    .mode_i    (mode_q),
    .rst_ena_i (rste_q),
    .nmi_sel_i (nmisel_q),
    .flag_i    (ovf_flag),
    .irq_o     (irq_interval_o),
    .rst_req_o (rst_pulse),
    .nmi_req_o (nmi_req_o)
  );

  assign rst_req_o = rst_pulse;

  // Read mux
  logic [DATA_W-1:0] rdata;

  always_comb begin
    rdata = '0;
    unique case (sel)
      SEL_COUNT:  rdata[CNT_W-1:0] = cnt_q;
      SEL_CTRL: begin
        rdata[CTRL_FLAG_B] = ovf_flag;
        rdata[CTRL_MODE_B] = mode_q;
        rdata[CTRL_RUN_B]  = run_q;
      end
      SEL_RSTCTL: begin
        rdata[RC_ENA_B] = rste_q;
        rdata[RC_NMI_B] = nmisel_q;
      end
      default:    rdata = '0;
    endcase
  end

  assign bus_rdata_o = rdata;

endmodule

// File: rtl/wdog_itimer_chk.sv
module wdog_itimer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_load,
  input logic             run,
  input logic             mode,
  input logic             rste,
  input logic [CNT_W-1:0] cnt,
  input logic             wrap,
  input logic             flag,
  input logic             irq,
  input logic             rst_req,
  input logic             nmi_req
);

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_load) |=> $stable(cnt)); // R1

  AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flag); // R2

  AST_IRQ_ONLY_INTERVAL: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !mode); // R5

  AST_RST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(mode && rste)); // R6

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R6

  AST_RST_AUTOCLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !flag); // R6

  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req && nmi_req)); // R7

endmodule

bind wdog_itimer wdog_itimer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .cnt_load (cnt_load),
  .run      (run_q),
  .mode     (mode_q),
  .rste     (rste_q),
  .cnt      (cnt_q),
  .wrap     (cnt_wrap),
  .flag     (ovf_flag),
  .irq      (irq_interval_o),
  .rst_req  (rst_req_o),
  .nmi_req  (nmi_req_o)
);

// File: tb/wdog_itimer_bench.sv
module wdog_itimer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SIG_RD  = 0;
  localparam int SIG_IRQ = 1;
  localparam int SIG_RST = 2;
  localparam int SIG_NMI = 3;

  logic       clk;
  logic       rst_n;
  logic       tick;
  logic       sel;
  logic       we;
  logic [1:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       irq, rreq, nreq;

  wdog_itimer u_wdog_itimer (
    .clk            (clk),
    .rst_n          (rst_n),
    .tick_i         (tick),
    .bus_sel_i      (sel),
    .bus_we_i       (we),
    .bus_addr_i     (addr),
    .bus_wdata_i    (wdata),
    .bus_rdata_o    (rdata),
    .irq_interval_o (irq),
    .rst_req_o      (rreq),
    .nmi_req_o      (nreq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    string      req;
    int         sig;
    logic [7:0] exp;
    int         due;
  } item_t;

  item_t sb[$];
  int    checks   = 0;
  int    failures = 0;

  // Monitor: compare every item that is due in this cycle
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due <= cyc) begin
        logic [7:0] act;
        case (sb[i].sig)
          SIG_RD:  act = rdata;
          SIG_IRQ: act = {7'd0, irq};
          SIG_RST: act = {7'd0, rreq};
          default: act = {7'd0, nreq};
        endcase
        checks++;
        if (act !== sb[i].exp || sb[i].due != cyc) begin
          failures++;
          $display("FAIL %s sig=%0d cycle=%0d actual=%h expected=%h",
                   sb[i].req, sb[i].sig, cyc, act, sb[i].exp);
        end
        sb.delete(i);
      end
    end
  end

  task automatic expect_at(string r, int s, logic [7:0] v, int dly);
    sb.push_back('{r, s, v, cyc + dly});
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    sel = 1'b0; we = 1'b0; tick = 1'b0; addr = 2'd0; wdata = 8'h00;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d, logic tk = 1'b0);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d; tick = tk;
    step();
  endtask

  task automatic rd(logic [1:0] a, logic [7:0] e, string r, logic tk = 1'b0);
    sel = 1'b1; we = 1'b0; addr = a; tick = tk;
    expect_at(r, SIG_RD, e, 0);
    step();
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) begin
      tick = 1'b1;
      step();
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL R9 watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; sel = 1'b0; we = 1'b0; tick = 1'b0; addr = 2'd0; wdata = 8'h00;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) step();

    // R9: reset state
    rd(2'd0, 8'h00, "R9");
    rd(2'd1, 8'h00, "R9");
    rd(2'd2, 8'h00, "R9");
    expect_at("R9", SIG_IRQ, 8'h0, 0);
    expect_at("R9", SIG_RST, 8'h0, 0);
    expect_at("R9", SIG_NMI, 8'h0, 0);
    step();

    // R1: no count while stopped, count when running, load beats tick
    wr(2'd0, 8'h10);
    ticks(3);
    rd(2'd0, 8'h10, "R1");
    wr(2'd1, 8'h20);
    ticks(3);
    rd(2'd0, 8'h13, "R1");
    wr(2'd0, 8'h40, 1'b1);
    rd(2'd0, 8'h40, "R1");

    // R2 / R5: wrap sets flag, interval irq follows
    wr(2'd0, 8'hFE);
    ticks(1);
    rd(2'd0, 8'hFF, "R2");
    ticks(1);
    expect_at("R5", SIG_IRQ, 8'h1, 0);
    rd(2'd0, 8'h00, "R2");

    // R3: clear needs a prior qualifying read; writing 1 has no effect
    wr(2'd1, 8'h20);
    expect_at("R3", SIG_IRQ, 8'h1, 0);
    step();
    rd(2'd1, 8'hA0, "R3");
    wr(2'd1, 8'hA0);
    rd(2'd1, 8'hA0, "R3");
    wr(2'd1, 8'h20);
    expect_at("R5", SIG_IRQ, 8'h0, 0);
    rd(2'd1, 8'h20, "R3");

    // R4: read in the wrap cycle does not qualify
    wr(2'd0, 8'hFF);
    rd(2'd1, 8'h20, "R4", 1'b1);
    wr(2'd1, 8'h20);
    expect_at("R4", SIG_IRQ, 8'h1, 0);
    step();
    rd(2'd1, 8'hA0, "R4");
    wr(2'd1, 8'h20);
    rd(2'd1, 8'h20, "R4");

    // R8: stopping the timer clears the flag without a read
    wr(2'd0, 8'hFF);
    ticks(1);
    expect_at("R8", SIG_IRQ, 8'h1, 0);
    step();
    wr(2'd1, 8'h00);
    expect_at("R8", SIG_IRQ, 8'h0, 0);
    rd(2'd1, 8'h00, "R8");

    // R6: watchdog reset pulse and auto-clear
    wr(2'd2, 8'h40);
    wr(2'd1, 8'h60);
    wr(2'd0, 8'hFF);
    expect_at("R6", SIG_RST, 8'h1, 1);
    expect_at("R5", SIG_IRQ, 8'h0, 1);
    expect_at("R6", SIG_RST, 8'h0, 2);
    ticks(1);
    rd(2'd1, 8'hE0, "R6");
    rd(2'd1, 8'h60, "R6");

    // R6: reset-enable off gates the request, flag stays
    wr(2'd2, 8'h00);
    wr(2'd0, 8'hFF);
    expect_at("R6", SIG_RST, 8'h0, 1);
    ticks(1);
    rd(2'd1, 8'hE0, "R6");
    wr(2'd1, 8'h40);
    rd(2'd1, 8'h40, "R8");

    // R7: NMI selected instead of reset
    wr(2'd2, 8'h60);
    rd(2'd2, 8'h60, "R10");
    wr(2'd1, 8'h60);
    wr(2'd0, 8'hFF);
    expect_at("R7", SIG_NMI, 8'h1, 1);
    expect_at("R7", SIG_RST, 8'h0, 1);
    expect_at("R7", SIG_NMI, 8'h0, 2);
    ticks(1);
    step();
    rd(2'd1, 8'hE0, "R7");

    // R10: read-back masks
    wr(2'd2, 8'hFF);
    rd(2'd2, 8'h60, "R10");
    rd(2'd3, 8'h00, "R10");
    wr(2'd1, 8'hFF);
    rd(2'd1, 8'hE0, "R10");

    repeat (3) step();
    if (sb.size() != 0) begin
      failures++;
      $display("FAIL R10 pending items actual=%0d expected=0", sb.size());
    end
    summary();
    $finish;
  end

endmodule